// File: doc/BRIEF.md
# SRAM Subarray Controller with Sector Wake Sequencing

This block is a synchronous controller wrapped around a behavioural 16 KB SRAM subarray. Requests arrive on a single valid/ready port with an address, a write flag and a 64-bit data word. A write stores the whole word in one array cycle. A read returns the word as two 32-bit halves on consecutive cycles. A configuration port loads repair entries that steer a faulty row or a faulty column slot to a spare one. The same port also loads the width of the body-bias pulse.

The array is split into two 256x256 sectors, each holding 256 rows of four 64-bit slots. Each sector has its own sleep, bias and wordline-enable output. Every access raises a bias pulse of programmable width in the addressed sector only. The wordline of that sector turns on one cycle after the pulse starts. A request aimed at a sleeping sector is held off with ready low while the sector wakes, and the wake is marked by its own bias pulse. An idle sector can be put back to sleep on request, and its contents are kept.

Top module: `sram_subarray_ctrl`

## Requirements
- R1: After reset every sector is asleep (sectorSleep all ones), no bias or wordline output is high, chunkValid is low and reqReady is low.
- R2: A write stores the full 64-bit word in one array cycle, and a later read of the same address returns that word.
- R3: A read accepted on clock edge E returns the low 32 bits with chunkIdx=0 and chunkValid high in the cycle after edge E+2, then the high 32 bits with chunkIdx=1 in the following cycle.
- R4: reqReady stays low while the second read half is still pending.
- R5: A request to a sleeping sector sees reqReady low. The controller drops that sector's sleep output and runs a wake pulse, and reqReady rises in the cycle after the pulse ends.
- R6: The bias pulse of an access starts in the cycle after acceptance and lasts W cycles. W is the 3-bit code loaded with cfgSel=4 plus one, so 1 to 8 cycles, and W is 1 after reset. The wordline enable of the sector turns on one cycle after the pulse starts.
- R7: Bias and wordline enable are raised only for the sector addressed by reqAddr[10]. No other sector's bias or wordline output is ever high at the same time.
- R8: Spare rows are loaded with cfgSel=0 and cfgSel=1, using cfgEnable and the row index in cfgValue. Requests accepted after the load that hit the enabled row index go to the spare row. Disabling the entry restores the original row.
- R9: Spare column slots are loaded with cfgSel=2 and cfgSel=3, using cfgEnable and the slot index in cfgValue[1:0]. Matching requests go to the spare slot.
- R10: sleepReq[s] on an idle, awake sector sets sectorSleep[s] on the next cycle and drops reqReady for that sector. The stored words survive until the sector is woken again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 11 | {sector, row[7:0], slot[1:0]} |
| reqWdata | input | 64 | Write word |
| reqReady | output | 1 | Request accepted on this edge when valid |
| cfgValid | input | 1 | Configuration load strobe |
| cfgSel | input | 3 | 0-1 spare row, 2-3 spare slot, 4 pulse width |
| cfgEnable | input | 1 | Enable bit of a repair entry |
| cfgValue | input | 8 | Faulty index or width code |
| sleepReq | input | 2 | Per-sector sleep request |
| sectorSleep | output | 2 | Per-sector sleep state |
| sectorBias | output | 2 | Per-sector bias pull-down pulse |
| sectorWlEn | output | 2 | Per-sector wordline enable |
| chunkValid | output | 1 | Read half valid |
| chunkIdx | output | 1 | 0 = low half, 1 = high half |
| chunkData | output | 32 | Read half |

## Verification
Repair redirection is invisible to any access pattern that writes and reads under the same repair setting, so it is the hardest behaviour to expose. The bench writes one word with repair off, enables a spare for that row or slot, and writes a second word to the same address. It then reads with the entry on and off and expects the two different words. The wake path is reached only by leaving a sector asleep or sending it back to sleep, and the bench does both with a long programmed pulse width.

// File: rtl/sa_pkg.sv
package sa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_PRE,
    ST_WL,
    ST_HI
  } sa_state_t;

  typedef struct packed {
    logic accept;
    logic doWrite;
    logic doRead;
    logic sendHi;
  } sa_strobe_t;
endpackage

// File: rtl/sa_remap.sv
module sa_remap #(
  parameter int ROWS       = 256,
  parameter int COLS       = 4,
  parameter int SPARE_ROWS = 2,
  parameter int SPARE_COLS = 2,
  parameter int ROW_W      = $clog2(ROWS),
  parameter int COL_W      = $clog2(COLS),
  parameter int PROW_W     = $clog2(ROWS + SPARE_ROWS),
  parameter int PCOL_W     = $clog2(COLS + SPARE_COLS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  input  logic [2:0]        cfgSel,
  input  logic              cfgEnable,
  input  logic [ROW_W-1:0]  cfgValue,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  output logic [PROW_W-1:0] physRow,
  output logic [PCOL_W-1:0] physCol
);
  logic [SPARE_ROWS-1:0] rowEn;
  logic [ROW_W-1:0]      rowIdx [SPARE_ROWS];
  logic [SPARE_COLS-1:0] colEn;
  logic [COL_W-1:0]      colIdx [SPARE_COLS];

  for (genvar k = 0; k < SPARE_ROWS; k++) begin : g_spareRow
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rowEn[k]  <= 1'b0;
        rowIdx[k] <= '0;
      end else if (cfgValid && cfgSel == 3'(k)) begin
        rowEn[k]  <= cfgEnable;
        rowIdx[k] <= cfgValue;
      end
    end
  end

  for (genvar k = 0; k < SPARE_COLS; k++) begin : g_spareCol
    always_ff @(posedge clk) begin
      if (!rstN) begin
        colEn[k]  <= 1'b0;
        colIdx[k] <= '0;
      end else if (cfgValid && cfgSel == 3'(SPARE_ROWS + k)) begin
        colEn[k]  <= cfgEnable;
        colIdx[k] <= cfgValue[COL_W-1:0];
      end
    end
  end

  // Lowest-numbered matching spare wins.
  always_comb begin
    physRow = PROW_W'(row);
    for (int k = SPARE_ROWS - 1; k >= 0; k--) begin
      if (rowEn[k] && rowIdx[k] == row) physRow = PROW_W'(ROWS + k);
    end
    physCol = PCOL_W'(col);
    for (int k = SPARE_COLS - 1; k >= 0; k--) begin
      if (colEn[k] && colIdx[k] == col) physCol = PCOL_W'(COLS + k);
    end
  end

  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(physRow) < ROWS + SPARE_ROWS); // R8
  AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(physCol) < COLS + SPARE_COLS); // R9
endmodule

// File: rtl/sa_dpath.sv
module sa_dpath
  import sa_pkg::*;
#(
  parameter int SECTORS    = 2,
  parameter int ROWS       = 256,
  parameter int COLS       = 4,
  parameter int SPARE_ROWS = 2,
  parameter int SPARE_COLS = 2,
  parameter int WORD_W     = 64,
  parameter int SEC_W      = $clog2(SECTORS),
  parameter int PROW_W     = $clog2(ROWS + SPARE_ROWS),
  parameter int PCOL_W     = $clog2(COLS + SPARE_COLS),
  parameter int HALF_W     = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  sa_strobe_t        strobe,
  input  logic [SEC_W-1:0]  sector,
  input  logic [PROW_W-1:0] physRow,
  input  logic [PCOL_W-1:0] physCol,
  input  logic [WORD_W-1:0] wdata,
  output logic              chunkValid,
  output logic              chunkIdx,
  output logic [HALF_W-1:0] chunkData
);
  localparam int PROWS = ROWS + SPARE_ROWS;
  localparam int PCOLS = COLS + SPARE_COLS;
  localparam int DEPTH = SECTORS * PROWS * PCOLS;
  localparam int IDX_W = $clog2(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  physIdx;
  logic [WORD_W-1:0] wordHold;
  logic [HALF_W-1:0] hiHold;

  // Physical location and data are captured at acceptance, so a later
  // repair load cannot move an access already in flight.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      physIdx  <= '0;
      wordHold <= '0;
    end else if (strobe.accept) begin
      physIdx  <= IDX_W'((int'(sector) * PROWS + int'(physRow)) * PCOLS
                         + int'(physCol));
      wordHold <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.doWrite) mem[physIdx] <= wordHold;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chunkValid <= 1'b0;
      chunkIdx   <= 1'b0;
      chunkData  <= '0;
      hiHold     <= '0;
    end else begin
      chunkValid <= 1'b0;
      if (strobe.doRead) begin
        chunkValid <= 1'b1;
        chunkIdx   <= 1'b0;
        chunkData  <= mem[physIdx][HALF_W-1:0];
        hiHold     <= mem[physIdx][WORD_W-1:HALF_W];
      end else if (strobe.sendHi) begin
        chunkValid <= 1'b1;
        chunkIdx   <= 1'b1;
        chunkData  <= hiHold;
      end
    end
  end

  AST_HI_FOLLOWS_LO: assert property (@(posedge clk) disable iff (!rstN)
    chunkValid && !chunkIdx |=> chunkValid && chunkIdx); // R3
  AST_HI_NEEDS_LO: assert property (@(posedge clk) disable iff (!rstN)
    chunkValid && chunkIdx |-> $past(chunkValid) && !$past(chunkIdx)); // R3
endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl
  import sa_pkg::*;
#(
  parameter int SECTORS   = 2,
  parameter int PW_W      = 3,
  parameter int WIDTH_SEL = 4,
  parameter int SEC_W     = $clog2(SECTORS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [SEC_W-1:0]   reqSector,
  output logic               reqReady,
  input  logic               cfgValid,
  input  logic [2:0]         cfgSel,
  input  logic [PW_W-1:0]    cfgWidth,
  input  logic [SECTORS-1:0] sleepReq,
  output sa_strobe_t         strobe,
  output logic [SECTORS-1:0] sectorSleep,
  output logic [SECTORS-1:0] sectorBias,
  output logic [SECTORS-1:0] sectorWlEn
);
  localparam int CNT_W = PW_W + 1;

  sa_state_t          state;
  logic [SEC_W-1:0]   curSec;
  logic               isWrite;
  logic [CNT_W-1:0]   pulseCnt;
  logic [PW_W-1:0]    widthCode;
  logic [SECTORS-1:0] sleepR;
  logic [SECTORS-1:0] biasR;
  logic [SECTORS-1:0] wlR;

  logic idleFree;
  logic secAwake;
  logic accept;
  logic startWake;

  always_comb begin
    idleFree  = (state == ST_IDLE) && (pulseCnt == '0);
    secAwake  = !sleepR[reqSector];
    reqReady  = idleFree && secAwake;
    accept    = reqValid && reqReady;
    startWake = idleFree && reqValid && !secAwake;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curSec  <= '0;
      isWrite <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_PRE;
            curSec  <= reqSector;
            isWrite <= reqWrite;
          end else if (startWake) begin
            state  <= ST_WAKE;
            curSec <= reqSector;
          end
        end
        ST_WAKE: if (pulseCnt == CNT_W'(1)) state <= ST_IDLE;
        ST_PRE:  state <= ST_WL;
        ST_WL:   state <= isWrite ? ST_IDLE : ST_HI;
        ST_HI:   state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // One shared pulse counter: only one sector is ever sequenced at a time.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt <= '0;
      biasR    <= '0;
    end else if (accept || startWake) begin
      pulseCnt <= CNT_W'(widthCode) + CNT_W'(1);
      biasR    <= SECTORS'(1) << reqSector;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - CNT_W'(1);
      if (pulseCnt == CNT_W'(1)) biasR <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) wlR <= '0;
    else if (state == ST_PRE) wlR <= SECTORS'(1) << curSec;
    else wlR <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) widthCode <= '0;
    else if (cfgValid && cfgSel == 3'(WIDTH_SEL)) widthCode <= cfgWidth;
  end

  for (genvar s = 0; s < SECTORS; s++) begin : g_sleep
    always_ff @(posedge clk) begin
      if (!rstN) sleepR[s] <= 1'b1;
      else if (startWake && reqSector == SEC_W'(s)) sleepR[s] <= 1'b0;
      else if (sleepReq[s] && idleFree && !(accept && reqSector == SEC_W'(s)))
        sleepR[s] <= 1'b1;
    end

    AST_BIAS_LEADS_WL: assert property (@(posedge clk) disable iff (!rstN)
      $rose(sectorWlEn[s]) |-> $past(sectorBias[s])); // R6
    AST_WL_AWAKE: assert property (@(posedge clk) disable iff (!rstN)
      sectorWlEn[s] |-> !sectorSleep[s]); // R5
    AST_BIAS_AWAKE: assert property (@(posedge clk) disable iff (!rstN)
      sectorBias[s] |-> !sectorSleep[s]); // R5
  end

  AST_BIAS_ONE_SECTOR: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sectorBias)); // R7
  AST_WL_ONE_SECTOR: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sectorWlEn)); // R7

  always_comb begin
    strobe.accept  = accept;
    strobe.doWrite = (state == ST_WL) && isWrite;
    strobe.doRead  = (state == ST_WL) && !isWrite;
    strobe.sendHi  = (state == ST_HI);
    sectorSleep    = sleepR;
    sectorBias     = biasR;
    sectorWlEn     = wlR;
  end
endmodule

// File: rtl/sram_subarray_ctrl.sv
module sram_subarray_ctrl
  import sa_pkg::*;
#(
  parameter int SECTORS    = 2,
  parameter int ROWS       = 256,
  parameter int COLS       = 4,
  parameter int SPARE_ROWS = 2,
  parameter int SPARE_COLS = 2,
  parameter int WORD_W     = 64,
  parameter int PW_W       = 3,
  parameter int SEC_W      = $clog2(SECTORS),
  parameter int ROW_W      = $clog2(ROWS),
  parameter int COL_W      = $clog2(COLS),
  parameter int ADDR_W     = SEC_W + ROW_W + COL_W,
  parameter int HALF_W     = WORD_W / 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [WORD_W-1:0]  reqWdata,
  output logic               reqReady,
  input  logic               cfgValid,
  input  logic [2:0]         cfgSel,
  input  logic               cfgEnable,
  input  logic [ROW_W-1:0]   cfgValue,
  input  logic [SECTORS-1:0] sleepReq,
  output logic [SECTORS-1:0] sectorSleep,
  output logic [SECTORS-1:0] sectorBias,
  output logic [SECTORS-1:0] sectorWlEn,
  output logic               chunkValid,
  output logic               chunkIdx,
  output logic [HALF_W-1:0]  chunkData
);
  localparam int PROW_W    = $clog2(ROWS + SPARE_ROWS);
  localparam int PCOL_W    = $clog2(COLS + SPARE_COLS);
  localparam int WIDTH_SEL = SPARE_ROWS + SPARE_COLS;

  logic [SEC_W-1:0]  reqSector;
  logic [ROW_W-1:0]  reqRow;
  logic [COL_W-1:0]  reqCol;
  logic [PROW_W-1:0] physRow;
  logic [PCOL_W-1:0] physCol;
  sa_strobe_t        strobe;

  assign reqSector = reqAddr[ADDR_W-1 -: SEC_W];
  assign reqRow    = reqAddr[COL_W +: ROW_W];
  assign reqCol    = reqAddr[COL_W-1:0];

  sa_remap #(
    .ROWS(ROWS), .COLS(COLS), .SPARE_ROWS(SPARE_ROWS), .SPARE_COLS(SPARE_COLS)
  ) u_remap (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgSel(cfgSel),
    .cfgEnable(cfgEnable), .cfgValue(cfgValue), .row(reqRow), .col(reqCol),
    .physRow(physRow), .physCol(physCol)
  );

  sa_ctrl #(
    .SECTORS(SECTORS), .PW_W(PW_W), .WIDTH_SEL(WIDTH_SEL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSector(reqSector), .reqReady(reqReady), .cfgValid(cfgValid),
    .cfgSel(cfgSel), .cfgWidth(cfgValue[PW_W-1:0]), .sleepReq(sleepReq),
    .strobe(strobe), .sectorSleep(sectorSleep), .sectorBias(sectorBias),
    .sectorWlEn(sectorWlEn)
  );

  sa_dpath #(
    .SECTORS(SECTORS), .ROWS(ROWS), .COLS(COLS), .SPARE_ROWS(SPARE_ROWS),
    .SPARE_COLS(SPARE_COLS), .WORD_W(WORD_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sector(reqSector),
    .physRow(physRow), .physCol(physCol), .wdata(reqWdata),
    .chunkValid(chunkValid), .chunkIdx(chunkIdx), .chunkData(chunkData)
  );

  AST_NO_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    chunkValid && !chunkIdx |-> !reqReady); // R4
  AST_READY_NEEDS_AWAKE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !$past(sectorSleep[reqSector])); // R5
endmodule

// File: tb/test_sram_subarray_ctrl.sv
module test_sram_subarray_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [10:0] reqAddr = '0;
  logic [63:0] reqWdata = '0;
  logic        reqReady;
  logic        cfgValid = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic        cfgEnable = 1'b0;
  logic [7:0]  cfgValue = '0;
  logic [1:0]  sleepReq = '0;
  logic [1:0]  sectorSleep;
  logic [1:0]  sectorBias;
  logic [1:0]  sectorWlEn;
  logic        chunkValid;
  logic        chunkIdx;
  logic [31:0] chunkData;

  int compared = 0;
  int mismatched = 0;
  int curW = 1;

  always #4 clk = ~clk;

  sram_subarray_ctrl i_sram_subarray_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .cfgValid(cfgValid), .cfgSel(cfgSel), .cfgEnable(cfgEnable),
    .cfgValue(cfgValue), .sleepReq(sleepReq), .sectorSleep(sectorSleep),
    .sectorBias(sectorBias), .sectorWlEn(sectorWlEn), .chunkValid(chunkValid),
    .chunkIdx(chunkIdx), .chunkData(chunkData)
  );

  function automatic logic [10:0] mkAddr(int sec, int row, int col);
    return {sec[0], row[7:0], col[1:0]};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic loadCfg(int sel, logic en, int value);
    @(negedge clk);
    cfgValid  = 1'b1;
    cfgSel    = sel[2:0];
    cfgEnable = en;
    cfgValue  = value[7:0];
    @(negedge clk);
    cfgValid = 1'b0;
  endtask

  // Access to an awake sector; checks R3, R4, R6 and R7 timing.
  task automatic access(logic wr, logic [10:0] addr, logic [63:0] wd,
                        output logic [63:0] rd);
    int sec = int'(addr[10]);
    int biasCnt = 0;
    logic [1:0] oneHot = 2'b01 << sec;
    rd = '0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    #1;
    chk("R5 ready for awake sector", 64'(reqReady), 64'd1);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (k == 1) reqValid = 1'b0;
      if (sectorBias[sec]) biasCnt++;
      if (k == 1) begin
        chk("R6 bias starts after accept", 64'(sectorBias), 64'(oneHot));
        chk("R6 wordline still off", 64'(sectorWlEn), 64'd0);
      end
      if (k == 2) chk("R7 wordline only addressed sector", 64'(sectorWlEn), 64'(oneHot));
      if (k == 3) begin
        if (wr) chk("R2 no read data on write", 64'(chunkValid), 64'd0);
        else begin
          chk("R3 low half valid/idx", {62'd0, chunkValid, chunkIdx}, 64'b10);
          chk("R4 ready low with high half pending", 64'(reqReady), 64'd0);
          rd[31:0] = chunkData;
        end
      end
      if (k == 4 && !wr) begin
        chk("R3 high half valid/idx", {62'd0, chunkValid, chunkIdx}, 64'b11);
        rd[63:32] = chunkData;
      end
      if (k >= 5) chk("R3 no extra halves", 64'(chunkValid), 64'd0);
    end
    chk("R6 bias pulse width", 64'(biasCnt), 64'(curW));
  endtask

  // Request to a sleeping sector; checks the R5 wake sequence.
  task automatic wake(int sec);
    int biasCnt = 0;
    bit done = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = mkAddr(sec, 0, 0);
    #1;
    chk("R5 ready low while asleep", 64'(reqReady), 64'd0);
    for (int k = 1; k <= 12 && !done; k++) begin
      @(negedge clk);
      if (k == 1) chk("R5 sleep dropped", 64'(sectorSleep[sec]), 64'd0);
      if (sectorBias[sec]) biasCnt++;
      if (reqReady) begin
        reqValid = 1'b0;
        chk("R5 ready rises after pulse", 64'(k), 64'(curW + 1));
        done = 1;
      end
    end
    reqValid = 1'b0;
    chk("R5 wake pulse width", 64'(biasCnt), 64'(curW));
  endtask

  task automatic tReset();
    #1;
    chk("R1 sleep after reset", 64'(sectorSleep), 64'b11);
    chk("R1 bias off", 64'(sectorBias), 64'd0);
    chk("R1 wordline off", 64'(sectorWlEn), 64'd0);
    chk("R1 no chunk", 64'(chunkValid), 64'd0);
    chk("R1 ready low", 64'(reqReady), 64'd0);
  endtask

  task automatic tBasic();
    logic [63:0] rd;
    wake(0);
    access(1'b1, mkAddr(0, 3, 1), 64'h0123_4567_89AB_CDEF, rd);
    access(1'b1, mkAddr(0, 255, 3), 64'hFFFF_0000_A5A5_5A5A, rd);
    access(1'b1, mkAddr(0, 0, 0), 64'h0, rd);
    access(1'b0, mkAddr(0, 3, 1), '0, rd);
    chk("R2 read back word A", rd, 64'h0123_4567_89AB_CDEF);
    access(1'b0, mkAddr(0, 255, 3), '0, rd);
    chk("R2 read back word B", rd, 64'hFFFF_0000_A5A5_5A5A);
    access(1'b0, mkAddr(0, 0, 0), '0, rd);
    chk("R2 read back zero word", rd, 64'h0);
  endtask

  task automatic tWidthAndSector1();
    logic [63:0] rd;
    loadCfg(4, 1'b0, 4);
    curW = 5;
    wake(1);
    access(1'b1, mkAddr(1, 3, 1), 64'hDEAD_BEEF_CAFE_F00D, rd);
    access(1'b0, mkAddr(1, 3, 1), '0, rd);
    chk("R7 sector 1 word separate", rd, 64'hDEAD_BEEF_CAFE_F00D);
    access(1'b0, mkAddr(0, 3, 1), '0, rd);
    chk("R7 sector 0 word untouched", rd, 64'h0123_4567_89AB_CDEF);
    loadCfg(4, 1'b0, 7);
    curW = 8;
    access(1'b0, mkAddr(1, 3, 1), '0, rd);
    chk("R6 read with maximum width", rd, 64'hDEAD_BEEF_CAFE_F00D);
    loadCfg(4, 1'b0, 0);
    curW = 1;
  endtask

  task automatic tRowRepair();
    logic [63:0] rd;
    access(1'b1, mkAddr(0, 7, 2), 64'h1111_1111_1111_1111, rd);
    loadCfg(1, 1'b1, 7);
    access(1'b1, mkAddr(0, 7, 2), 64'h2222_2222_2222_2222, rd);
    access(1'b0, mkAddr(0, 7, 2), '0, rd);
    chk("R8 spare row holds new word", rd, 64'h2222_2222_2222_2222);
    access(1'b0, mkAddr(0, 8, 2), '0, rd);
    access(1'b1, mkAddr(0, 8, 2), 64'h3333, rd);
    access(1'b0, mkAddr(0, 8, 2), '0, rd);
    chk("R8 neighbour row not redirected", rd, 64'h3333);
    loadCfg(1, 1'b0, 7);
    access(1'b0, mkAddr(0, 7, 2), '0, rd);
    chk("R8 original row restored", rd, 64'h1111_1111_1111_1111);
  endtask

  task automatic tColRepair();
    logic [63:0] rd;
    access(1'b1, mkAddr(0, 20, 2), 64'h4444_0000_4444_0000, rd);
    loadCfg(2, 1'b1, 2);
    access(1'b1, mkAddr(0, 20, 2), 64'h5555_0000_5555_0000, rd);
    access(1'b0, mkAddr(0, 20, 2), '0, rd);
    chk("R9 spare slot holds new word", rd, 64'h5555_0000_5555_0000);
    loadCfg(2, 1'b0, 2);
    access(1'b0, mkAddr(0, 20, 2), '0, rd);
    chk("R9 original slot restored", rd, 64'h4444_0000_4444_0000);
  endtask

  task automatic tSleep();
    logic [63:0] rd;
    @(negedge clk);
    reqAddr = mkAddr(0, 3, 1);
    sleepReq = 2'b01;
    @(negedge clk);
    sleepReq = 2'b00;
    chk("R10 sector 0 asleep", 64'(sectorSleep), 64'b01);
    chk("R10 ready low for sleeping sector", 64'(reqReady), 64'd0);
    wake(0);
    access(1'b0, mkAddr(0, 3, 1), '0, rd);
    chk("R10 contents kept over sleep", rd, 64'h0123_4567_89AB_CDEF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tBasic();
    tWidthAndSector1();
    tRowRepair();
    tColRepair();
    tSleep();
    summary();
    $finish;
  end
endmodule